// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit for a single-bus processor datapath. A microprogram counter addresses a constant control store inside the block. Each control word carries a 20-bit field-encoded microinstruction and a sequencing extension. A decoder expands the encoded fields into one-hot datapath strobes:

- bus source select
- two destination-load groups
- ALU function and operand select
- memory read and write
- wait-for-memory
- end-of-instruction

The shared fetch microroutine sits at addresses 0 to 2. Address 3 dispatches on the opcode held in the instruction register. Each instruction's microroutine finishes with an End word, which returns the counter to 0. Branch microinstructions test the negative or zero condition flag. While a word requests a wait for memory and memory has not yet completed, the counter holds. The decoded strobes therefore stay asserted for the whole wait.

The datapath registers, the ALU and the bus are outside this block. It drives their control lines and reads back only the instruction register, the memory-complete strobe and the condition flags.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_ni` is low, `upc_o` is 0 and the outputs decode the fetch word at address 0. That word drives source PC (`src_oh_o`=0x001), loads Z and MAR (`dst_oh_o`=0x084), asserts `mem_rd_o` and `sel_four_o`, and drives ALU function 0 (add).
- R2: Outside the other cases, the counter advances by one per clock. The fetch runs 0→1→2→3, with address 1 driving source Z and loading PC and Y (0x401, wait set), and address 2 driving source MDR and loading IR (0x002).
- R3: When `wait_mfc_o` is 1 and `mfc_i` is 0, `upc_o` and all decoded outputs hold. This overrides End and branching.
- R4: At address 3 the counter is loaded from opcode `ir_i[7:5]`; `ir_i[4:0]` are ignored. The opcode map is:
  - 0: indirect add, entry 4
  - 1: unconditional branch, entry 20
  - 2: branch if negative, entry 25
  - 3: register move, entry 10
  - 4: store, entry 12
  - 5: XOR, entry 15
  - 6: branch if zero, entry 22
- R5: Opcode 7 has no microroutine; dispatch sends the counter to 0.
- R6: The negative flag is `flags_i[0]`. At address 25 the counter goes to 0 when it is 0. Otherwise it steps to 26, where source is offset (0x100), Z is loaded and `sel_four_o`=0, and then to 27, where source is Z, PC is loaded and End is set.
- R7: The zero flag is `flags_i[1]`. At address 22 the counter goes to 0 when it is 0. Otherwise it steps to 23 (offset into Z) and then 24 (Z into PC, End).
- R8: When End is set and no wait is pending, the next counter value is 0.
- R9: `src_oh_o` has at most one bit set. The bit order is PC, MDR, Z, R0, R1, R2, R3, TEMP, offset (bits 0 to 8). The dispatch word drives no source.
- R10: `dst_oh_o` has one bit from each destination group. The bit order is PC, IR, Z, R0, R1, R2, R3, MAR, MDR, TEMP, Y (bits 0 to 10). In the indirect-add routine:
  - 4: R3 to MAR, read
  - 5: R1 to Y, wait
  - 6: MDR plus Y into Z
  - 7: Z into R1, End
- R11: The ALU function field is always driven. The XOR routine drives function 15 at address 16, with `sel_four_o` at 0.
- R12: `mem_rd_o` and `mem_wr_o` are never both 1. The store routine writes at address 13 with source R2 and destination MDR (0x100); wait and End are set in the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ir_i | input | 8 | Instruction register contents; opcode in the top three bits |
| mfc_i | input | 1 | Memory function complete |
| flags_i | input | 2 | Condition flags: bit 0 negative, bit 1 zero |
| upc_o | output | 5 | Microprogram counter |
| src_oh_o | output | 9 | One-hot bus source strobes |
| dst_oh_o | output | 11 | Destination load strobes |
| alu_fn_o | output | 4 | ALU function code |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| sel_four_o | output | 1 | ALU A input takes constant 4 instead of Y |
| wait_mfc_o | output | 1 | Current word waits for memory completion |
| end_o | output | 1 | Current word ends the instruction |

## Verification
Each opcode is run through the full fetch and its own microroutine. Checking every step's counter and strobes tells the dispatch map, plain increment and the End return apart. The two flag-tested routines are run with the tested flag both clear and set, so a taken branch is distinguished from a fall-through. An inverted flag polarity or a wrong flag bit shows as a wrong address. Holding `mfc_i` low on the fetch wait word and on the store word, which also carries End, separates a proper hold from early advance and from End taking priority over the wait. Garbage in the low IR bits and the unused opcode show that only the opcode field steers dispatch.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int unsigned UW_W  = 20;
  localparam int unsigned SEQ_W = 3;
  localparam int unsigned SRC_N = 9;
  localparam int unsigned DST_N = 11;

  typedef struct packed {
    logic [3:0] f_src;
    logic [2:0] f_dst1;
    logic [2:0] f_dst2;
    logic [3:0] f_alu;
    logic [1:0] f_mem;
    logic       f_sel4;
    logic       f_wmfc;
    logic       f_end;
    logic       f_rsvd;
  } uword_t;

  // bus source codes
  localparam logic [3:0] S_NONE = 4'd0;
  localparam logic [3:0] S_PC   = 4'd1;
  localparam logic [3:0] S_MDR  = 4'd2;
  localparam logic [3:0] S_Z    = 4'd3;
  localparam logic [3:0] S_R0   = 4'd4;
  localparam logic [3:0] S_R1   = 4'd5;
  localparam logic [3:0] S_R2   = 4'd6;
  localparam logic [3:0] S_R3   = 4'd7;
  localparam logic [3:0] S_TMP  = 4'd10;
  localparam logic [3:0] S_OFF  = 4'd11;

  // first destination group
  localparam logic [2:0] D1_NONE = 3'd0;
  localparam logic [2:0] D1_PC   = 3'd1;
  localparam logic [2:0] D1_IR   = 3'd2;
  localparam logic [2:0] D1_Z    = 3'd3;
  localparam logic [2:0] D1_R0   = 3'd4;
  localparam logic [2:0] D1_R1   = 3'd5;
  localparam logic [2:0] D1_R2   = 3'd6;
  localparam logic [2:0] D1_R3   = 3'd7;

  // second destination group
  localparam logic [2:0] D2_NONE = 3'd0;
  localparam logic [2:0] D2_MAR  = 3'd1;
  localparam logic [2:0] D2_MDR  = 3'd2;
  localparam logic [2:0] D2_TMP  = 3'd3;
  localparam logic [2:0] D2_Y    = 3'd4;

  localparam logic [3:0] A_ADD = 4'd0;
  localparam logic [3:0] A_SUB = 4'd1;
  localparam logic [3:0] A_XOR = 4'd15;

  localparam logic [1:0] M_NONE = 2'd0;
  localparam logic [1:0] M_RD   = 2'd1;
  localparam logic [1:0] M_WR   = 2'd2;

  // one-hot output bit positions
  localparam int unsigned SB_PC = 0, SB_MDR = 1, SB_Z = 2, SB_R0 = 3, SB_TMP = 7, SB_OFF = 8;
  localparam int unsigned DB_PC = 0, DB_IR = 1, DB_Z = 2, DB_R0 = 3,
                          DB_MAR = 7, DB_MDR = 8, DB_TMP = 9, DB_Y = 10;

  typedef enum logic [SEQ_W-1:0] {
    SQ_STEP = 3'd0,
    SQ_DISP = 3'd1,
    SQ_NCLR = 3'd2,
    SQ_NSET = 3'd3,
    SQ_ZCLR = 3'd4,
    SQ_ZSET = 3'd5,
    SQ_JMP  = 3'd6,
    SQ_RSV  = 3'd7
  } seq_e;

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0]            addr_i,
  output logic [UW_W+SEQ_W+AW-1:0] word_o
);

  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned CW_W  = UW_W + SEQ_W + AW;

  function automatic logic [CW_W-1:0] mk(
    input logic [3:0] src, input logic [2:0] d1, input logic [2:0] d2,
    input logic [3:0] alu, input logic [1:0] mem, input logic s4,
    input logic w, input logic e, input seq_e sq, input int unsigned tgt);
    uword_t u;
    u.f_src  = src;
    u.f_dst1 = d1;
    u.f_dst2 = d2;
    u.f_alu  = alu;
    u.f_mem  = mem;
    u.f_sel4 = s4;
    u.f_wmfc = w;
    u.f_end  = e;
    u.f_rsvd = 1'b0;
    return {AW'(tgt), sq, u};
  endfunction

  function automatic logic [CW_W-1:0] rom_word(input int unsigned a);
    case (a)
      // fetch
      0:  return mk(S_PC,  D1_Z,    D2_MAR,  A_ADD, M_RD,   1'b1, 1'b0, 1'b0, SQ_STEP, 0);
      1:  return mk(S_Z,   D1_PC,   D2_Y,    A_ADD, M_NONE, 1'b0, 1'b1, 1'b0, SQ_STEP, 0);
      2:  return mk(S_MDR, D1_IR,   D2_NONE, A_ADD, M_NONE, 1'b0, 1'b0, 1'b0, SQ_STEP, 0);
      3:  return mk(S_NONE,D1_NONE, D2_NONE, A_ADD, M_NONE, 1'b0, 1'b0, 1'b0, SQ_DISP, 0);
      // add (R3),R1
      4:  return mk(S_R3,  D1_NONE, D2_MAR,  A_ADD, M_RD,   1'b0, 1'b0, 1'b0, SQ_STEP, 0);
      5:  return mk(S_R1,  D1_NONE, D2_Y,    A_ADD, M_NONE, 1'b0, 1'b1, 1'b0, SQ_STEP, 0);
      6:  return mk(S_MDR, D1_Z,    D2_NONE, A_ADD, M_NONE, 1'b0, 1'b0, 1'b0, SQ_STEP, 0);
      7:  return mk(S_Z,   D1_R1,   D2_NONE, A_ADD, M_NONE, 1'b0, 1'b0, 1'b1, SQ_STEP, 0);
      // move R1 -> R2
      10: return mk(S_R1,  D1_R2,   D2_NONE, A_ADD, M_NONE, 1'b0, 1'b0, 1'b1, SQ_STEP, 0);
      // store R2 -> [R1]
      12: return mk(S_R1,  D1_NONE, D2_MAR,  A_ADD, M_NONE, 1'b0, 1'b0, 1'b0, SQ_STEP, 0);
      13: return mk(S_R2,  D1_NONE, D2_MDR,  A_ADD, M_WR,   1'b0, 1'b1, 1'b1, SQ_STEP, 0);
      // xor R1 into R0
      15: return mk(S_R0,  D1_NONE, D2_Y,    A_ADD, M_NONE, 1'b0, 1'b0, 1'b0, SQ_STEP, 0);
      16: return mk(S_R1,  D1_Z,    D2_NONE, A_XOR, M_NONE, 1'b0, 1'b0, 1'b0, SQ_STEP, 0);
      17: return mk(S_Z,   D1_R0,   D2_NONE, A_ADD, M_NONE, 1'b0, 1'b0, 1'b1, SQ_STEP, 0);
      // unconditional branch
      20: return mk(S_OFF, D1_Z,    D2_NONE, A_ADD, M_NONE, 1'b0, 1'b0, 1'b0, SQ_STEP, 0);
      21: return mk(S_Z,   D1_PC,   D2_NONE, A_ADD, M_NONE, 1'b0, 1'b0, 1'b1, SQ_STEP, 0);
      // branch if zero
      22: return mk(S_NONE,D1_NONE, D2_NONE, A_ADD, M_NONE, 1'b0, 1'b0, 1'b0, SQ_ZCLR, 0);
      23: return mk(S_OFF, D1_Z,    D2_NONE, A_ADD, M_NONE, 1'b0, 1'b0, 1'b0, SQ_STEP, 0);
      24: return mk(S_Z,   D1_PC,   D2_NONE, A_ADD, M_NONE, 1'b0, 1'b0, 1'b1, SQ_STEP, 0);
      // branch if negative
      25: return mk(S_NONE,D1_NONE, D2_NONE, A_ADD, M_NONE, 1'b0, 1'b0, 1'b0, SQ_NCLR, 0);
      26: return mk(S_OFF, D1_Z,    D2_NONE, A_ADD, M_NONE, 1'b0, 1'b0, 1'b0, SQ_STEP, 0);
      27: return mk(S_Z,   D1_PC,   D2_NONE, A_ADD, M_NONE, 1'b0, 1'b0, 1'b1, SQ_STEP, 0);
      // unused words restart fetch
      default: return mk(S_NONE, D1_NONE, D2_NONE, A_ADD, M_NONE, 1'b0, 1'b0, 1'b1, SQ_STEP, 0);
    endcase
  endfunction

  logic [CW_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = rom_word(i);
  end

  assign word_o = rom[addr_i];

endmodule

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  uword_t           uw_i,
  output logic [SRC_N-1:0] src_oh_o,
  output logic [DST_N-1:0] dst_oh_o,
  output logic [3:0]       alu_fn_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             sel_four_o,
  output logic             wait_mfc_o,
  output logic             end_o
);

  always_comb begin
    src_oh_o = '0;
    case (uw_i.f_src)
      S_PC:                    src_oh_o[SB_PC]  = 1'b1;
      S_MDR:                   src_oh_o[SB_MDR] = 1'b1;
      S_Z:                     src_oh_o[SB_Z]   = 1'b1;
      S_R0, S_R1, S_R2, S_R3:  src_oh_o[SB_R0 + int'(uw_i.f_src[1:0])] = 1'b1;
      S_TMP:                   src_oh_o[SB_TMP] = 1'b1;
      S_OFF:                   src_oh_o[SB_OFF] = 1'b1;
      default:                 src_oh_o = '0;
    endcase
  end

  always_comb begin
    dst_oh_o = '0;
    case (uw_i.f_dst1)
      D1_PC:                      dst_oh_o[DB_PC] = 1'b1;
      D1_IR:                      dst_oh_o[DB_IR] = 1'b1;
      D1_Z:                       dst_oh_o[DB_Z]  = 1'b1;
      D1_R0, D1_R1, D1_R2, D1_R3: dst_oh_o[DB_R0 + int'(uw_i.f_dst1[1:0])] = 1'b1;
      default: ;
    endcase
    case (uw_i.f_dst2)
      D2_MAR:  dst_oh_o[DB_MAR] = 1'b1;
      D2_MDR:  dst_oh_o[DB_MDR] = 1'b1;
      D2_TMP:  dst_oh_o[DB_TMP] = 1'b1;
      D2_Y:    dst_oh_o[DB_Y]   = 1'b1;
      default: ;
    endcase
  end

  assign alu_fn_o   = uw_i.f_alu;
  assign mem_rd_o   = (uw_i.f_mem == M_RD);
  assign mem_wr_o   = (uw_i.f_mem == M_WR);
  assign sel_four_o = uw_i.f_sel4;
  assign wait_mfc_o = uw_i.f_wmfc;
  assign end_o      = uw_i.f_end;

  assert_src_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_oh_o));

  assert_dst_groups_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(dst_oh_o) <= 2);

  assert_mem_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int unsigned AW   = 5,
  parameter int unsigned OP_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   upc_i,
  input  seq_e            seq_i,
  input  logic [AW-1:0]   tgt_i,
  input  logic            wmfc_i,
  input  logic            end_i,
  input  logic            mfc_i,
  input  logic [1:0]      flags_i,
  input  logic [OP_W-1:0] op_i,
  output logic [AW-1:0]   nxt_o
);

  logic          neg, zero, stall;
  logic [AW-1:0] inc, start;

  assign neg   = flags_i[0];
  assign zero  = flags_i[1];
  assign stall = wmfc_i & ~mfc_i;
  assign inc   = upc_i + AW'(1);

  // starting address generator
  always_comb begin
    case (int'(op_i))
      0:       start = AW'(4);
      1:       start = AW'(20);
      2:       start = AW'(25);
      3:       start = AW'(10);
      4:       start = AW'(12);
      5:       start = AW'(15);
      6:       start = AW'(22);
      default: start = '0;
    endcase
  end

  always_comb begin
    if (stall)       nxt_o = upc_i;
    else if (end_i)  nxt_o = '0;
    else begin
      case (seq_i)
        SQ_DISP: nxt_o = start;
        SQ_NCLR: nxt_o = neg  ? inc : tgt_i;
        SQ_NSET: nxt_o = neg  ? tgt_i : inc;
        SQ_ZCLR: nxt_o = zero ? inc : tgt_i;
        SQ_ZSET: nxt_o = zero ? tgt_i : inc;
        SQ_JMP:  nxt_o = tgt_i;
        default: nxt_o = inc;
      endcase
    end
  end

  assert_brn_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_i == AW'(25) && !neg && !stall) |=> (upc_i == '0));

  assert_brz_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upc_i == AW'(22) && !zero && !stall) |=> (upc_i == '0));

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int unsigned AW   = 5,
  parameter int unsigned IR_W = 8,
  parameter int unsigned OP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IR_W-1:0]  ir_i,
  input  logic             mfc_i,
  input  logic [1:0]       flags_i,
  output logic [AW-1:0]    upc_o,
  output logic [SRC_N-1:0] src_oh_o,
  output logic [DST_N-1:0] dst_oh_o,
  output logic [3:0]       alu_fn_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             sel_four_o,
  output logic             wait_mfc_o,
  output logic             end_o
);

  localparam int unsigned CW_W = UW_W + SEQ_W + AW;

  logic [AW-1:0]   upc_q, upc_d;
  logic [CW_W-1:0] word;
  uword_t          uw;
  seq_e            seq;
  logic [AW-1:0]   tgt;
  logic            unused_bits;

  assign uw  = uword_t'(word[UW_W-1:0]);
  assign seq = seq_e'(word[UW_W +: SEQ_W]);
  assign tgt = word[CW_W-1 -: AW];
  assign unused_bits = ^{ir_i[IR_W-OP_W-1:0], uw.f_rsvd};

  useq_store #(.AW(AW)) u_store (
    .addr_i (upc_q),
    .word_o (word)
  );

  useq_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .uw_i       (uw),
    .src_oh_o   (src_oh_o),
    .dst_oh_o   (dst_oh_o),
    .alu_fn_o   (alu_fn_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .sel_four_o (sel_four_o),
    .wait_mfc_o (wait_mfc_o),
    .end_o      (end_o)
  );

  useq_next #(.AW(AW), .OP_W(OP_W)) u_next (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upc_i   (upc_q),
    .seq_i   (seq),
    .tgt_i   (tgt),
    .wmfc_i  (uw.f_wmfc),
    .end_i   (uw.f_end),
    .mfc_i   (mfc_i),
    .flags_i (flags_i),
    .op_i    (ir_i[IR_W-1 -: OP_W]),
    .nxt_o   (upc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upc_q <= '0;
    else         upc_q <= upc_d;
  end

  assign upc_o = upc_q;

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq == SQ_STEP && !end_o && !(wait_mfc_o && !mfc_i))
    |=> (upc_q == $past(upc_q) + AW'(1)));

  assert_stall_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_mfc_o && !mfc_i) |=> ($stable(upc_q) && $stable(src_oh_o) && $stable(dst_oh_o)));

  assert_end_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_o && !(wait_mfc_o && !mfc_i)) |=> (upc_q == '0));

endmodule

// File: tb/tb_useq_ctrl.sv
module tb_useq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ir = '0;
  logic        mfc = 1'b1;
  logic [1:0]  flags = '0;
  logic [4:0]  upc;
  logic [8:0]  src;
  logic [10:0] dst;
  logic [3:0]  alu;
  logic        rd, wr, s4, wt, en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  useq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .ir_i(ir), .mfc_i(mfc), .flags_i(flags),
    .upc_o(upc), .src_oh_o(src), .dst_oh_o(dst), .alu_fn_o(alu),
    .mem_rd_o(rd), .mem_wr_o(wr), .sel_four_o(s4), .wait_mfc_o(wt), .end_o(en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic look(input string tag, input int a, input int s, input int d);
    chk({tag, " upc"}, int'(upc), a);
    chk({tag, " src"}, int'(src), s);
    chk({tag, " dst"}, int'(dst), d);
  endtask

  // from address 0 through dispatch word at 3
  task automatic fetch(input logic [2:0] op);
    ir = {op, 5'b10101};
    step(); look("R2 fetch1", 1, 'h004, 'h401); chk("R2 wait1", int'(wt), 1);
    step(); look("R2 fetch2", 2, 'h002, 'h002);
    step(); look("R9 disp", 3, 0, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #12;
    @(negedge clk);
    look("R1 reset", 0, 'h001, 'h084);
    chk("R1 rd", int'(rd), 1);
    chk("R1 sel4", int'(s4), 1);
    chk("R1 alu", int'(alu), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_add();
    fetch(3'd0);
    step(); look("R4 add4", 4, 'h040, 'h080); chk("R10 rd4", int'(rd), 1);
    step(); look("R10 add5", 5, 'h010, 'h400); chk("R10 wait5", int'(wt), 1);
    step(); look("R10 add6", 6, 'h002, 'h004); chk("R11 sel6", int'(s4), 0);
    step(); look("R10 add7", 7, 'h004, 'h010); chk("R8 end7", int'(en), 1);
    step(); chk("R8 back", int'(upc), 0);
  endtask

  task automatic t_stall();
    mfc = 1'b0;
    ir = {3'd3, 5'b0};
    step(); look("R3 enter", 1, 'h004, 'h401);
    for (int i = 0; i < 4; i++) begin
      step(); look("R3 hold", 1, 'h004, 'h401); chk("R3 wait", int'(wt), 1);
    end
    mfc = 1'b1;
    step(); chk("R3 release", int'(upc), 2);
    step(); chk("R3 disp", int'(upc), 3);
    step(); look("R4 mov", 10, 'h010, 'h020); chk("R8 mov end", int'(en), 1);
    step(); chk("R8 mov back", int'(upc), 0);
  endtask

  task automatic t_brn();
    flags = 2'b10;  // zero set, negative clear
    fetch(3'd2);
    step(); chk("R4 brn entry", int'(upc), 25);
    step(); chk("R6 not taken", int'(upc), 0);
    flags = 2'b01;
    fetch(3'd2);
    step(); chk("R6 entry", int'(upc), 25);
    step(); look("R6 add off", 26, 'h100, 'h004); chk("R6 sel4", int'(s4), 0);
    step(); look("R6 load pc", 27, 'h004, 'h001); chk("R6 end", int'(en), 1);
    step(); chk("R6 back", int'(upc), 0);
    flags = 2'b00;
  endtask

  task automatic t_brz();
    flags = 2'b01;  // negative set, zero clear
    fetch(3'd6);
    step(); chk("R4 brz entry", int'(upc), 22);
    step(); chk("R7 not taken", int'(upc), 0);
    flags = 2'b10;
    fetch(3'd6);
    step(); step(); look("R7 add off", 23, 'h100, 'h004);
    step(); look("R7 load pc", 24, 'h004, 'h001); chk("R7 end", int'(en), 1);
    step(); chk("R7 back", int'(upc), 0);
    flags = 2'b00;
  endtask

  task automatic t_bra();
    fetch(3'd1);
    step(); look("R4 bra", 20, 'h100, 'h004);
    step(); look("R4 bra pc", 21, 'h004, 'h001);
    step(); chk("R8 bra back", int'(upc), 0);
  endtask

  task automatic t_store();
    fetch(3'd4);
    step(); look("R4 st12", 12, 'h010, 'h080);
    mfc = 1'b0;
    step(); look("R12 st13", 13, 'h020, 'h100);
    chk("R12 wr", int'(wr), 1); chk("R12 rd", int'(rd), 0);
    chk("R12 end", int'(en), 1);
    step(); chk("R3 end held", int'(upc), 13);
    mfc = 1'b1;
    step(); chk("R8 st back", int'(upc), 0);
  endtask

  task automatic t_xor();
    fetch(3'd5);
    step(); look("R4 xor15", 15, 'h008, 'h400);
    step(); look("R11 xor16", 16, 'h010, 'h004);
    chk("R11 alu", int'(alu), 15); chk("R11 sel", int'(s4), 0);
    step(); look("R11 xor17", 17, 'h004, 'h008);
    step(); chk("R8 xor back", int'(upc), 0);
  endtask

  task automatic t_bad();
    fetch(3'd7);
    step(); chk("R5 unused op", int'(upc), 0);
    look("R5 refetch", 0, 'h001, 'h084);
  endtask

  initial begin
    t_reset();
    t_add();
    t_stall();
    t_brn();
    t_brz();
    t_bra();
    t_store();
    t_xor();
    t_bad();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule